// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter with Buffer Rollover

This block sits behind a CAN receiver and decides what happens to each frame the receiver has finished. It compares the frame's identifier against six programmable filters. Each filter has an identifier value and an extended-frame flag. The filters form two groups, and each group has its own mask. Filters 0 and 1 feed receive buffer 0 under mask 0. Filters 2 to 5 feed receive buffer 1 under mask 1. The block has three possible results: a load strobe naming the target buffer and the filter that hit, an overflow pulse for the buffer that was still full, or nothing.

The identifier input is always 29 bits wide. The 11-bit base identifier sits in bits 28:18 and the 18-bit extension sits in bits 17:0. A standard frame uses only the base part. Each buffer has a two-bit receive-mode field that narrows filtering to one frame type or turns filtering off. A rollover control sends a frame that buffer 0 accepted into buffer 1 when buffer 0 is still occupied. Masks, filters and controls are static configuration inputs, held stable while frames arrive.

Top module: `can_accept_filter`

## Requirements
- R1: While rst_n is low, and after it is released until the first valid frame, load_vld, load_buf, load_hit, ovf0 and ovf1 are all 0.
- R2: Identifier bit b takes part in a comparison only when bit b of the group's mask is 1. A mask bit of 0 makes that bit a don't-care.
- R3: For a standard frame (frm_ext=0), only bits 28:18 are compared. A filter can hit only when its filt_ext flag equals frm_ext.
- R4: Filters 0 and 1 use mask0 and target buffer 0 (load_buf=0). Filters 2 to 5 use mask1 and target buffer 1 (load_buf=1).
- R5: When several filters hit, load_hit reports the lowest-numbered one. Acceptance by buffer 0 takes priority over buffer 1.
- R6: If rollover_en=1, a frame accepted for buffer 0 while buf0_full=1 and buf1_full=0 loads buffer 1, and load_hit keeps the filter-0/1 number.
- R7: A frame accepted for buffer 0 while buf0_full=1 pulses ovf0 when rollover_en=0. It pulses ovf1 when rollover_en=1 and buf1_full=1. No load occurs in either case.
- R8: A frame accepted only by the buffer 1 group while buf1_full=1 pulses ovf1 and causes no load.
- R9: Receive mode per buffer: 00 accepts matching frames of both types, 01 matching standard frames only, 10 matching extended frames only, and 11 every frame. In mode 11, load_hit is the lowest hitting filter of the group, or the group's first filter (0 or 2) if none hits.
- R10: Results appear on the clock edge that samples frm_valid=1 and last exactly one cycle. Nothing is produced when frm_valid=0.
- R11: A frame that no group accepts produces no load and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: a received frame is ready for filtering |
| frm_id | input | 29 | Identifier; base in 28:18, extension in 17:0 |
| frm_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| buf0_full | input | 1 | Receive buffer 0 still holds an unread frame |
| buf1_full | input | 1 | Receive buffer 1 still holds an unread frame |
| rollover_en | input | 1 | Send buffer-0 acceptances to buffer 1 when buffer 0 is full |
| rx_mode0 | input | 2 | Receive mode for buffer 0 |
| rx_mode1 | input | 2 | Receive mode for buffer 1 |
| mask0 | input | 29 | Mask of the buffer 0 filter group |
| mask1 | input | 29 | Mask of the buffer 1 filter group |
| filt_id | input | 174 | Six filter identifiers, filter f in bits f*29 +: 29 |
| filt_ext | input | 6 | Extended-frame flag of each filter |
| load_vld | output | 1 | Store the frame into load_buf |
| load_buf | output | 1 | Target buffer of the load |
| load_hit | output | 3 | Number of the filter that accepted the frame |
| ovf0 | output | 1 | Pulse: frame lost because buffer 0 was full |
| ovf1 | output | 1 | Pulse: frame lost because buffer 1 was full |

## Verification
The bench uses the default parameters: an 11-bit base, an 18-bit extension, two filters for buffer 0 and four for buffer 1. With these values the uneven split, duplicate filters within a group and standard-versus-extended masking can all be reached. Directed frames cover rollover, both overflow paths and every receive mode. Random frames are built from filter values, with the don't-care bits perturbed, so that hits are frequent. Random fullness and mode settings then exercise the priority and rollover paths many times against the behavioural model.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

  typedef enum logic [1:0] {
    RXM_ANY = 2'b00,
    RXM_STD = 2'b01,
    RXM_EXT = 2'b10,
    RXM_ALL = 2'b11
  } rx_mode_e;

  // Does the receive mode let this frame type through the filters?
  function automatic logic mode_allows(rx_mode_e mode, logic ext);
    case (mode)
      RXM_STD: return !ext;
      RXM_EXT: return ext;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/can_id_match.sv
module can_id_match #(
  parameter int BASE_W = 11,
  parameter int EXT_W  = 18,
  localparam int ID_W  = BASE_W + EXT_W
) (
  input  logic [ID_W-1:0] id_i,
  input  logic            ext_i,
  input  logic [ID_W-1:0] filt_i,
  input  logic            filt_ext_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            hit_o
);

  // Masked difference; standard frames look only at the base field.
  function automatic logic id_cmp(logic [ID_W-1:0] id, logic ext,
                                  logic [ID_W-1:0] filt, logic fext,
                                  logic [ID_W-1:0] mask);
    logic [ID_W-1:0] diff;
    diff = (id ^ filt) & mask;
    if (fext != ext) return 1'b0;
    if (ext)         return (diff == '0);
    return (diff[ID_W-1 -: BASE_W] == '0);
  endfunction

  assign hit_o = id_cmp(id_i, ext_i, filt_i, filt_ext_i, mask_i);

endmodule

// File: rtl/can_prio_pick.sv
module can_prio_pick #(
  parameter int N = 2,
  parameter int W = 3
) (
  input  logic [N-1:0] hits_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  // Lowest set index wins; zero when nothing hits.
  always_comb begin
    any_o = |hits_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = W'(i);
    end
  end

endmodule

// File: rtl/can_route.sv
module can_route #(
  parameter int W = 3
) (
  input  logic         acc0_i,
  input  logic         acc1_i,
  input  logic [W-1:0] hit0_i,
  input  logic [W-1:0] hit1_i,
  input  logic         full0_i,
  input  logic         full1_i,
  input  logic         roll_i,
  output logic         ld_o,
  output logic         ld_buf_o,
  output logic [W-1:0] ld_hit_o,
  output logic         ov0_o,
  output logic         ov1_o
);

  always_comb begin
    ld_o     = 1'b0;
    ld_buf_o = 1'b0;
    ld_hit_o = '0;
    ov0_o    = 1'b0;
    ov1_o    = 1'b0;
    if (acc0_i) begin
      if (!full0_i) begin
        ld_o     = 1'b1;
        ld_hit_o = hit0_i;
      end else if (roll_i) begin
        if (!full1_i) begin
          ld_o     = 1'b1;
          ld_buf_o = 1'b1;
          ld_hit_o = hit0_i;
        end else begin
          ov1_o = 1'b1;
        end
      end else begin
        ov0_o = 1'b1;
      end
    end else if (acc1_i) begin
      if (!full1_i) begin
        ld_o     = 1'b1;
        ld_buf_o = 1'b1;
        ld_hit_o = hit1_i;
      end else begin
        ov1_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int BASE_W = 11,
  parameter int EXT_W  = 18,
  parameter int NF0    = 2,
  parameter int NF1    = 4,
  localparam int ID_W  = BASE_W + EXT_W,
  localparam int NF    = NF0 + NF1,
  localparam int HIT_W = $clog2(NF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_valid,
  input  logic [ID_W-1:0]    frm_id,
  input  logic               frm_ext,
  input  logic               buf0_full,
  input  logic               buf1_full,
  input  logic               rollover_en,
  input  logic [1:0]         rx_mode0,
  input  logic [1:0]         rx_mode1,
  input  logic [ID_W-1:0]    mask0,
  input  logic [ID_W-1:0]    mask1,
  input  logic [NF*ID_W-1:0] filt_id,
  input  logic [NF-1:0]      filt_ext,
  output logic               load_vld,
  output logic               load_buf,
  output logic [HIT_W-1:0]   load_hit,
  output logic               ovf0,
  output logic               ovf1
);

  logic [NF-1:0]    flt_hit;
  logic             any0, any1;
  logic [HIT_W-1:0] idx0, idx1, hit1_g;
  rx_mode_e         mode0, mode1;
  logic             acc0, acc1;
  logic             nx_ld, nx_buf, nx_ov0, nx_ov1;
  logic [HIT_W-1:0] nx_hit;

  for (genvar f = 0; f < NF; f++) begin : g_flt
    can_id_match #(.BASE_W(BASE_W), .EXT_W(EXT_W)) u_match (
      .id_i      (frm_id),
      .ext_i     (frm_ext),
      .filt_i    (filt_id[f*ID_W +: ID_W]),
      .filt_ext_i(filt_ext[f]),
      .mask_i    ((f < NF0) ? mask0 : mask1),
      .hit_o     (flt_hit[f])
    );
  end

  can_prio_pick #(.N(NF0), .W(HIT_W)) u_pick0 (
    .hits_i(flt_hit[NF0-1:0]), .any_o(any0), .idx_o(idx0)
  );
  can_prio_pick #(.N(NF1), .W(HIT_W)) u_pick1 (
    .hits_i(flt_hit[NF-1:NF0]), .any_o(any1), .idx_o(idx1)
  );

  assign hit1_g = idx1 + HIT_W'(NF0);
  assign mode0  = rx_mode_e'(rx_mode0);
  assign mode1  = rx_mode_e'(rx_mode1);

  // Group acceptance events, brought out for the checker.
  assign acc0 = frm_valid &&
                ((mode0 == RXM_ALL) || (any0 && mode_allows(mode0, frm_ext)));
  assign acc1 = frm_valid &&
                ((mode1 == RXM_ALL) || (any1 && mode_allows(mode1, frm_ext)));

  can_route #(.W(HIT_W)) u_route (
    .acc0_i  (acc0),
    .acc1_i  (acc1),
    .hit0_i  (idx0),
    .hit1_i  (hit1_g),
    .full0_i (buf0_full),
    .full1_i (buf1_full),
    .roll_i  (rollover_en),
    .ld_o    (nx_ld),
    .ld_buf_o(nx_buf),
    .ld_hit_o(nx_hit),
    .ov0_o   (nx_ov0),
    .ov1_o   (nx_ov1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_vld <= 1'b0;
      load_buf <= 1'b0;
      load_hit <= '0;
      ovf0     <= 1'b0;
      ovf1     <= 1'b0;
    end else begin
      load_vld <= nx_ld;
      load_buf <= nx_buf;
      load_hit <= nx_hit;
      ovf0     <= nx_ov0;
      ovf1     <= nx_ov1;
    end
  end

endmodule

// File: rtl/can_accept_filter_chk.sv
module can_accept_filter_chk #(
  parameter int NF0   = 2,
  parameter int HIT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid,
  input logic             buf0_full,
  input logic             buf1_full,
  input logic             rollover_en,
  input logic [1:0]       rx_mode0,
  input logic             acc0,
  input logic             acc1,
  input logic             load_vld,
  input logic             load_buf,
  input logic [HIT_W-1:0] load_hit,
  input logic             ovf0,
  input logic             ovf1
);

  localparam logic [HIT_W-1:0] G1_FIRST = HIT_W'(NF0);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_valid) |-> !load_vld && !ovf0 && !ovf1);

  a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_vld, ovf0, ovf1}));

  a_r4_group0_hit: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld && !load_buf |-> load_hit < G1_FIRST);

  a_r6_rollover_only: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld && load_buf && (load_hit < G1_FIRST) |->
      $past(rollover_en) && $past(buf0_full));

  a_r8_buf1_free: assert property (@(posedge clk) disable iff (!rst_n)
    load_vld && load_buf |-> !$past(buf1_full));

  a_r5_buf0_priority: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc0) && !$past(buf0_full) |-> load_vld && !load_buf);

  a_r11_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc0) && !$past(acc1) |-> !load_vld && !ovf0 && !ovf1);

  a_r9_accept_all: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frm_valid) && ($past(rx_mode0) == 2'b11) |->
      (load_vld && (load_hit < G1_FIRST)) || ovf0 || ovf1);

endmodule

bind can_accept_filter can_accept_filter_chk #(.NF0(NF0), .HIT_W(HIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frm_valid  (frm_valid),
  .buf0_full  (buf0_full),
  .buf1_full  (buf1_full),
  .rollover_en(rollover_en),
  .rx_mode0   (rx_mode0),
  .acc0       (acc0),
  .acc1       (acc1),
  .load_vld   (load_vld),
  .load_buf   (load_buf),
  .load_hit   (load_hit),
  .ovf0       (ovf0),
  .ovf1       (ovf1)
);

// File: tb/can_accept_filter_bench.sv
module can_accept_filter_bench;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frm_valid, frm_ext, buf0_full, buf1_full, rollover_en;
  logic [28:0]   frm_id, mask0, mask1;
  logic [1:0]    rx_mode0, rx_mode1;
  logic [173:0]  filt_id;
  logic [5:0]    filt_ext;
  logic          load_vld, load_buf, ovf0, ovf1;
  logic [2:0]    load_hit;

  logic [28:0]   fid [6];
  logic          fext [6];
  int            checks = 0, fails = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  can_accept_filter u_can_accept_filter (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
    .frm_ext(frm_ext), .buf0_full(buf0_full), .buf1_full(buf1_full),
    .rollover_en(rollover_en), .rx_mode0(rx_mode0), .rx_mode1(rx_mode1),
    .mask0(mask0), .mask1(mask1), .filt_id(filt_id), .filt_ext(filt_ext),
    .load_vld(load_vld), .load_buf(load_buf), .load_hit(load_hit),
    .ovf0(ovf0), .ovf1(ovf1)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pack_cfg();
    for (int f = 0; f < 6; f++) begin
      filt_id[f*29 +: 29] = fid[f];
      filt_ext[f]         = fext[f];
    end
  endtask

  function automatic bit mode_ok(logic [1:0] m, logic ext);
    if (m == 2'd1) return !ext;
    if (m == 2'd2) return ext;
    return 1'b1;
  endfunction

  // Behavioural reference: returns {vld, buf, hit[2:0], ovf0, ovf1}
  function automatic logic [6:0] model(output string tag);
    int first0 = -1, first1 = -1;
    bit a0, a1;
    int h0, h1;
    for (int f = 0; f < 6; f++) begin
      bit ok = (fext[f] == frm_ext);
      logic [28:0] mk = (f < 2) ? mask0 : mask1;
      for (int b = (frm_ext ? 0 : 18); b < 29; b++)
        if (mk[b] && (frm_id[b] != fid[f][b])) ok = 0;
      if (ok && f < 2 && first0 < 0) first0 = f;
      if (ok && f >= 2 && first1 < 0) first1 = f;
    end
    h0 = (first0 < 0) ? 0 : first0;
    h1 = (first1 < 0) ? 2 : first1;
    a0 = frm_valid && (rx_mode0 == 2'd3 || (first0 >= 0 && mode_ok(rx_mode0, frm_ext)));
    a1 = frm_valid && (rx_mode1 == 2'd3 || (first1 >= 0 && mode_ok(rx_mode1, frm_ext)));
    if (!frm_valid) begin tag = "R10"; return 7'd0; end
    if (a0) begin
      if (!buf0_full) begin tag = (rx_mode0 == 2'd3) ? "R9" : "R5"; return {2'b10, 3'(h0), 2'b00}; end
      if (!rollover_en) begin tag = "R7"; return 7'b0000010; end
      if (!buf1_full) begin tag = "R6"; return {2'b11, 3'(h0), 2'b00}; end
      tag = "R7"; return 7'b0000001;
    end
    if (a1) begin
      if (!buf1_full) begin tag = frm_ext ? "R4" : "R3"; return {2'b11, 3'(h1), 2'b00}; end
      tag = "R8"; return 7'b0000001;
    end
    tag = "R11";
    return 7'd0;
  endfunction

  // One clock: predict from the current inputs, sample after the edge.
  task automatic tick();
    logic [6:0] e;
    string tag;
    pack_cfg();
    e = model(tag);
    @(posedge clk);
    #2;
    chk({tag, " load_vld"}, load_vld, e[6]);
    chk({tag, " load_buf"}, load_buf, e[5]);
    chk({tag, " load_hit"}, load_hit, e[4:2]);
    chk({tag, " ovf0"}, ovf0, e[1]);
    chk({tag, " ovf1"}, ovf1, e[0]);
  endtask

  task automatic frame(logic [28:0] id, logic ext);
    frm_valid = 1; frm_id = id; frm_ext = ext;
    tick();
    frm_valid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    rst_n = 0; frm_valid = 0; frm_id = '0; frm_ext = 0;
    buf0_full = 0; buf1_full = 0; rollover_en = 0;
    rx_mode0 = 0; rx_mode1 = 0;
    mask0 = {11'h7FF, 18'h0}; mask1 = 29'h1FFFFFFF;
    fid[0] = {11'h123, 18'h0}; fext[0] = 0;
    fid[1] = {11'h123, 18'h0}; fext[1] = 0;
    fid[2] = 29'h0ABCDEF;      fext[2] = 1;
    fid[3] = {11'h055, 18'h0}; fext[3] = 0;
    fid[4] = 29'h0ABCDEF;      fext[4] = 1;
    fid[5] = 29'h0000001;      fext[5] = 1;
    pack_cfg();
    // R1: a matching frame during reset produces nothing
    frm_valid = 1; frm_id = {11'h123, 18'h0};
    repeat (2) @(posedge clk);
    frm_valid = 0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1 load_vld in reset", load_vld, 0);
    chk("R1 ovf in reset", ovf0 | ovf1, 0);
    rst_n = 1;
    tick();
    chk("R1 load_vld after reset", load_vld, 0);

    // R2/R3/R5: extension bits ignored under mask0, lowest duplicate wins
    frame({11'h123, 18'h3ABCD}, 0);
    chk("R5 buf0 load", load_vld, 1);
    chk("R5 lowest hit", load_hit, 0);
    tick();
    chk("R10 pulse ends", load_vld, 0);
    // R4: extended frame goes to group 1, lowest of filters 2 and 4
    frame(29'h0ABCDEF, 1);
    chk("R4 buf1", load_buf, 1);
    chk("R4 hit", load_hit, 2);
    // R2: one differing bit under a full mask rejects
    frame(29'h0ABCDEE, 1);
    chk("R2 masked bit differs", load_vld, 0);
    // R3: extended flag mismatch with matching base bits rejects
    frame({11'h123, 18'h5}, 1);
    chk("R3 ext flag mismatch", load_vld, 0);
    // R6: rollover
    buf0_full = 1; rollover_en = 1;
    frame({11'h123, 18'h0}, 0);
    chk("R6 to buf1", load_buf, 1);
    chk("R6 keeps hit", load_hit, 0);
    // R7: both full with rollover, then no rollover
    buf1_full = 1;
    frame({11'h123, 18'h0}, 0);
    chk("R7 ovf1 via rollover", ovf1, 1);
    rollover_en = 0;
    frame({11'h123, 18'h0}, 0);
    chk("R7 ovf0", ovf0, 1);
    chk("R7 no load", load_vld, 0);
    // R8: group 1 frame with buffer 1 full
    buf0_full = 0;
    frame(29'h0ABCDEF, 1);
    chk("R8 ovf1", ovf1, 1);
    buf1_full = 0;
    // R11: nothing matches
    frame({11'h7FF, 18'h0}, 0);
    chk("R11 no load", load_vld | ovf0 | ovf1, 0);
    // R9: modes
    rx_mode1 = 2'd1;
    frame(29'h0ABCDEF, 1);
    chk("R9 std-only rejects ext", load_vld, 0);
    rx_mode1 = 2'd2;
    frame({11'h055, 18'h0}, 0);
    chk("R9 ext-only rejects std", load_vld, 0);
    rx_mode1 = 2'd3;
    frame({11'h7FF, 18'h0}, 0);
    chk("R9 accept-all hit", load_hit, 2);
    rx_mode0 = 2'd3;
    frame({11'h7FF, 18'h0}, 0);
    chk("R9 accept-all buf0", load_buf, 0);
    rx_mode0 = 0; rx_mode1 = 0;

    // Random traffic built around the filters
    for (int n = 0; n < 4000; n++) begin
      int f;
      if (n % 250 == 0) begin
        mask0 = 29'($urandom); mask1 = 29'($urandom);
        for (int k = 0; k < 6; k++) begin
          fid[k] = 29'($urandom); fext[k] = 1'($urandom);
        end
        if (($urandom % 3) == 0) fid[1] = fid[0];
        rx_mode0 = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
        rx_mode1 = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
      end
      f = $urandom % 6;
      if (($urandom % 4) != 0) begin
        frm_id  = fid[f] ^ (29'($urandom) & ~((f < 2) ? mask0 : mask1) & 29'($urandom));
        frm_ext = fext[f];
      end else begin
        frm_id = 29'($urandom); frm_ext = 1'($urandom);
      end
      frm_valid   = ($urandom % 4) != 0;
      buf0_full   = ($urandom % 3) == 0;
      buf1_full   = ($urandom % 3) == 0;
      rollover_en = 1'($urandom);
      tick();
    end
    frm_valid = 0;
    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule